// File: doc/BRIEF.md
# Frame-Sequenced Window Move Controller

This block steers the video serial streams of a two-memory frame store so that a group of windows can be moved across the screen without any processor copying pixels. The store has a visible on-screen memory and a hidden display memory of the same geometry. In normal refresh the monitor shows the on-screen memory, and every pixel it shifts out is also copied, unshifted, into the display memory. That copy is the starting condition for a move.

A window manager requests a move by supplying three things: a shift vector, a membership mask of window tags to move, and a membership mask of tags that may lie on top of the moved windows. The block latches all of them. At the next frame boundary it runs three whole frames in a fixed order:

- a shifted copy of the moving windows into display memory;
- an unshifted copy of the covering windows into display memory;
- a write-back frame, in which the monitor shows display memory and every pixel is written back into on-screen memory.

Per pixel, the block produces the write enables, the display-memory write coordinates and the monitor source select. The random-access ports stay free for rendering throughout the sequence.

Top module: `wmv_seq_top`

## Requirements
- R1: While idle or armed, the monitor source is on-screen memory (`mon_from_dm`=0), every pixel strobe raises `dm_we` with `dm_x`/`dm_y` equal to the incoming `pix_x`/`pix_y`, and `osm_we` stays 0.
- R2: A start request is taken only while idle. It sets `busy` in the next cycle and arms the block. Armed, the block keeps normal refresh until the next `frame_start`, and that pulse begins the shifted-copy frame.
- R3: In the shifted-copy frame, a strobed pixel is written to display memory only when bit `pix_wid` of the latched move mask is 1. The write address is `pix_x+shift_x`, `pix_y+shift_y`, and the monitor still shows on-screen memory.
- R4: In the shifted-copy frame, a pixel whose shifted column lies outside 0..H_RES-1, or whose shifted row lies outside 0..V_RES-1, is dropped (`dm_we`=0) and never wrapped.
- R5: In the cover-copy frame, a strobed pixel is written to display memory only when bit `pix_wid` of the latched cover mask is 1, at the unshifted address. The monitor still shows on-screen memory.
- R6: In the write-back frame, `mon_from_dm`=1, `dm_we`=0, and every pixel strobe raises `osm_we`.
- R7: Each of the three copy phases lasts exactly from one `frame_start` pulse to the next. The phase never changes without a `frame_start`.
- R8: The `frame_start` that ends the write-back frame returns the block to idle. In the following cycle, `done` is high for exactly one cycle and `busy` is low.
- R9: `copy_cursor` follows every pixel write during normal refresh. During the sequence it follows a pixel write only when the option bit latched at start was 1.
- R10: The shift, the masks and the cursor option are captured when the start is taken. Later changes to those inputs, and start requests made while busy, have no effect on the running sequence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| frame_start | input | 1 | One-cycle pulse at each frame boundary |
| pix_strobe | input | 1 | A serial pixel is present this cycle |
| pix_x | input | X_W | Column of the present pixel |
| pix_y | input | Y_W | Row of the present pixel |
| pix_wid | input | WID_W | Window tag of the present on-screen pixel |
| start_req | input | 1 | Move request from the window manager |
| shift_x | input | X_W+1 | Signed horizontal shift |
| shift_y | input | Y_W+1 | Signed vertical shift |
| move_mask | input | 2**WID_W | Tags of the windows to move |
| cover_mask | input | 2**WID_W | Tags allowed to cover the moved windows |
| cursor_opt | input | 1 | Carry cursor planes during the move |
| dm_we | output | 1 | Display-memory serial write enable |
| dm_x | output | X_W | Display-memory write column |
| dm_y | output | Y_W | Display-memory write row |
| osm_we | output | 1 | On-screen memory write-back enable |
| mon_from_dm | output | 1 | Monitor fed from display memory |
| copy_cursor | output | 1 | Cursor planes take part in this write |
| busy | output | 1 | Sequence armed or running |
| done | output | 1 | One-cycle completion pulse |

## Verification
The assertions assume that `frame_start` and `pix_strobe` are never high in the same cycle. They also assume that `pix_x`/`pix_y` stay inside the screen whenever a strobe is present. The bench keeps to both rules: it sends each frame pulse in a cycle of its own and then sweeps every column and row of a small 16x8 screen. Window tags follow an arithmetic pattern, so every tag value meets both masks in each frame. The shift vectors include the extreme negative and positive values, so the discard edges are reached.

// File: rtl/wmv_pkg.sv
package wmv_pkg;
   typedef enum logic [2:0] {
      WMV_IDLE  = 3'd0,
      WMV_ARMED = 3'd1,
      WMV_MOVE  = 3'd2,
      WMV_COVER = 3'd3,
      WMV_WBACK = 3'd4
   } wmv_phase_e;
endpackage

// File: rtl/wmv_phase_fsm.sv
module wmv_phase_fsm
   import wmv_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  logic       frame_start,
   input  logic       start_req,
   output wmv_phase_e phase,
   output logic       done
);
   wmv_phase_e nxt;

   always_comb begin
      nxt = phase;
      unique case (phase)
         WMV_IDLE:  if (start_req)   nxt = WMV_ARMED;
         WMV_ARMED: if (frame_start) nxt = WMV_MOVE;
         WMV_MOVE:  if (frame_start) nxt = WMV_COVER;
         WMV_COVER: if (frame_start) nxt = WMV_WBACK;
         WMV_WBACK: if (frame_start) nxt = WMV_IDLE;
         default:                    nxt = WMV_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         phase <= WMV_IDLE;
         done  <= 1'b0;
      end else begin
         phase <= nxt;
         done  <= (phase == WMV_WBACK) && frame_start;
      end
   end

   p_idle_stay_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (phase == WMV_IDLE && !start_req) |=> phase == WMV_IDLE);
   p_armed_wait_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (phase == WMV_ARMED && !frame_start) |=> phase == WMV_ARMED);
   p_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
      ((phase == WMV_MOVE || phase == WMV_COVER || phase == WMV_WBACK) && !frame_start)
      |=> phase == $past(phase));
   p_step_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (phase == WMV_MOVE && frame_start) |=> phase == WMV_COVER);
   p_done_r8: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(done) |-> phase == WMV_IDLE);
   p_done_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);
endmodule

// File: rtl/wmv_tag_match.sv
module wmv_tag_match #(
   parameter int WID_W = 8,
   localparam int NTAG = 1 << WID_W
) (
   input  logic [NTAG-1:0]  mask,
   input  logic [WID_W-1:0] tag,
   output logic             hit
);
   assign hit = mask[tag];
endmodule

// File: rtl/wmv_shift_addr.sv
module wmv_shift_addr #(
   parameter int RES = 1280,
   parameter int W   = 11
) (
   input  logic [W-1:0]      coord,
   input  logic signed [W:0] shift,
   input  logic              apply,
   output logic [W-1:0]      dest,
   output logic              in_range
);
   logic signed [W+1:0] sum;

   always_comb begin
      sum = $signed({2'b00, coord}) + $signed({shift[W], shift});
      if (apply) begin
         dest     = sum[W-1:0];
         in_range = (sum >= 0) && (sum < RES);
      end else begin
         dest     = coord;
         in_range = 1'b1;
      end
   end
endmodule

// File: rtl/wmv_seq_top.sv
module wmv_seq_top
   import wmv_pkg::*;
#(
   parameter int H_RES      = 1280,
   parameter int V_RES      = 1024,
   parameter int WID_W      = 8,
   parameter bit HAS_CURSOR = 1'b1,
   localparam int X_W  = $clog2(H_RES),
   localparam int Y_W  = $clog2(V_RES),
   localparam int NTAG = 1 << WID_W
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                frame_start,
   input  logic                pix_strobe,
   input  logic [X_W-1:0]      pix_x,
   input  logic [Y_W-1:0]      pix_y,
   input  logic [WID_W-1:0]    pix_wid,
   input  logic                start_req,
   input  logic signed [X_W:0] shift_x,
   input  logic signed [Y_W:0] shift_y,
   input  logic [NTAG-1:0]     move_mask,
   input  logic [NTAG-1:0]     cover_mask,
   input  logic                cursor_opt,
   output logic                dm_we,
   output logic [X_W-1:0]      dm_x,
   output logic [Y_W-1:0]      dm_y,
   output logic                osm_we,
   output logic                mon_from_dm,
   output logic                copy_cursor,
   output logic                busy,
   output logic                done
);
   initial begin
      assert (H_RES >= 2 && V_RES >= 2) else $fatal(1, "screen too small");
      assert (WID_W >= 1 && WID_W <= 10) else $fatal(1, "tag width out of range");
   end

   wmv_phase_e phase;
   logic [NTAG-1:0]     mv_q, cv_q;
   logic signed [X_W:0] sx_q;
   logic signed [Y_W:0] sy_q;
   logic                cur_q;
   logic                take;

   assign take = (phase == WMV_IDLE) && start_req;

   wmv_phase_fsm u_fsm (
      .clk(clk), .rst_n(rst_n), .frame_start(frame_start),
      .start_req(start_req), .phase(phase), .done(done)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mv_q  <= '0;
         cv_q  <= '0;
         sx_q  <= '0;
         sy_q  <= '0;
         cur_q <= 1'b0;
      end else if (take) begin
         mv_q  <= move_mask;
         cv_q  <= cover_mask;
         sx_q  <= shift_x;
         sy_q  <= shift_y;
         cur_q <= cursor_opt;
      end
   end

   logic mv_hit, cv_hit;
   wmv_tag_match #(.WID_W(WID_W)) u_mv (.mask(mv_q), .tag(pix_wid), .hit(mv_hit));
   wmv_tag_match #(.WID_W(WID_W)) u_cv (.mask(cv_q), .tag(pix_wid), .hit(cv_hit));

   logic in_move;
   logic x_ok, y_ok;
   assign in_move = (phase == WMV_MOVE);

   wmv_shift_addr #(.RES(H_RES), .W(X_W)) u_sx (
      .coord(pix_x), .shift(sx_q), .apply(in_move), .dest(dm_x), .in_range(x_ok));
   wmv_shift_addr #(.RES(V_RES), .W(Y_W)) u_sy (
      .coord(pix_y), .shift(sy_q), .apply(in_move), .dest(dm_y), .in_range(y_ok));

   always_comb begin
      dm_we       = 1'b0;
      osm_we      = 1'b0;
      mon_from_dm = 1'b0;
      unique case (phase)
         WMV_IDLE, WMV_ARMED: dm_we = pix_strobe;
         WMV_MOVE:  dm_we = pix_strobe && mv_hit && x_ok && y_ok;
         WMV_COVER: dm_we = pix_strobe && cv_hit;
         WMV_WBACK: begin
            mon_from_dm = 1'b1;
            osm_we      = pix_strobe;
         end
         default: dm_we = 1'b0;
      endcase
   end

   assign busy = (phase != WMV_IDLE);

   generate
      if (HAS_CURSOR) begin : g_cursor
         assign copy_cursor = (dm_we || osm_we) && (!busy || phase == WMV_ARMED || cur_q);
      end else begin : g_no_cursor
         assign copy_cursor = 1'b0;
      end
   endgenerate

   p_dest_range_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (dm_we && in_move) |-> (dm_x < H_RES && dm_y < V_RES));
   p_mon_excl_r6: assert property (@(posedge clk) disable iff (!rst_n)
      mon_from_dm |-> !dm_we);
   p_wb_only_r6: assert property (@(posedge clk) disable iff (!rst_n)
      osm_we |-> mon_from_dm);
   p_latch_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (phase != WMV_IDLE) |=> ($stable(sx_q) && $stable(sy_q) && $stable(mv_q) && $stable(cv_q)));
   p_cursor_r9: assert property (@(posedge clk) disable iff (!rst_n)
      copy_cursor |-> (dm_we || osm_we));
endmodule

// File: tb/wmv_seq_top_tb_top.sv
`timescale 1ns/1ps
module wmv_seq_top_tb_top;
   localparam int H = 16, V = 8, WW = 3;
   localparam int XW = 4, YW = 3, NT = 8;

   logic clk = 1'b0, rst_n = 1'b0;
   logic frame_start = 0, pix_strobe = 0, start_req = 0, cursor_opt = 0;
   logic [XW-1:0] pix_x = '0;
   logic [YW-1:0] pix_y = '0;
   logic [WW-1:0] pix_wid = '0;
   logic signed [XW:0] shift_x = '0;
   logic signed [YW:0] shift_y = '0;
   logic [NT-1:0] move_mask = '0, cover_mask = '0;
   logic dm_we, osm_we, mon_from_dm, copy_cursor, busy, done;
   logic [XW-1:0] dm_x;
   logic [YW-1:0] dm_y;

   int errors = 0, checks = 0;

   always #2 clk = ~clk;

   wmv_seq_top #(.H_RES(H), .V_RES(V), .WID_W(WW), .HAS_CURSOR(1'b1)) dut_i (
      .clk(clk), .rst_n(rst_n), .frame_start(frame_start), .pix_strobe(pix_strobe),
      .pix_x(pix_x), .pix_y(pix_y), .pix_wid(pix_wid), .start_req(start_req),
      .shift_x(shift_x), .shift_y(shift_y), .move_mask(move_mask),
      .cover_mask(cover_mask), .cursor_opt(cursor_opt), .dm_we(dm_we),
      .dm_x(dm_x), .dm_y(dm_y), .osm_we(osm_we), .mon_from_dm(mon_from_dm),
      .copy_cursor(copy_cursor), .busy(busy), .done(done));

   task automatic chk(input string req, input int act, input int exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual=%0d expected=%0d at %0t", req, act, exp, $time);
      end
   endtask

   task automatic frame_pulse();
      @(negedge clk);
      pix_strobe  = 0;
      frame_start = 1;
      @(negedge clk);
      frame_start = 0;
   endtask

   // phase codes used by the model: 0 normal, 1 shifted copy, 2 cover copy, 3 write-back
   task automatic sweep(input int ph, input int sx, input int sy,
                        input logic [NT-1:0] mv, input logic [NT-1:0] cv,
                        input bit cur, input int salt);
      for (int yy = 0; yy < V; yy++) begin
         for (int xx = 0; xx < H; xx++) begin
            int wid, dx, dy, ewe, eosm, emon, ecur;
            bit ok;
            wid = (xx * 3 + yy * 5 + salt) % NT;
            @(negedge clk);
            pix_strobe = 1;
            pix_x = xx[XW-1:0];
            pix_y = yy[YW-1:0];
            pix_wid = wid[WW-1:0];
            #1;
            dx = xx; dy = yy; eosm = 0; emon = 0;
            case (ph)
               0: ewe = 1;
               1: begin
                  dx = xx + sx; dy = yy + sy;
                  ok = (dx >= 0) && (dx < H) && (dy >= 0) && (dy < V);
                  ewe = (mv[wid] && ok) ? 1 : 0;
               end
               2: ewe = cv[wid] ? 1 : 0;
               default: begin ewe = 0; eosm = 1; emon = 1; end
            endcase
            ecur = (ph == 0) ? 1 : (((ewe | eosm) != 0 && cur) ? 1 : 0);
            case (ph)
               0: chk("R1 dm_we normal", dm_we, ewe);
               1: chk("R3/R4 dm_we shifted", dm_we, ewe);
               2: chk("R5 dm_we cover", dm_we, ewe);
               default: chk("R6 dm_we writeback", dm_we, ewe);
            endcase
            chk("R6 osm_we", osm_we, eosm);
            chk("R1/R6 mon_from_dm", mon_from_dm, emon);
            chk("R9 copy_cursor", copy_cursor, ecur);
            if (ewe != 0) begin
               chk("R3 dm_x", dm_x, dx);
               chk("R3 dm_y", dm_y, dy);
            end
            if (ph == 1 && (dx < 0 || dx >= H || dy < 0 || dy >= V))
               chk("R4 discard", dm_we, 0);
         end
      end
      @(negedge clk);
      pix_strobe = 0;
   endtask

   task automatic run_move(input int sx, input int sy, input logic [NT-1:0] mv,
                           input logic [NT-1:0] cv, input bit cur, input int salt);
      @(negedge clk);
      start_req = 1;
      shift_x = sx[XW:0];
      shift_y = sy[YW:0];
      move_mask = mv;
      cover_mask = cv;
      cursor_opt = cur;
      @(negedge clk);
      start_req = 0;
      chk("R2 busy after start", busy, 1);
      // R10: scramble the request inputs after acceptance
      move_mask = ~mv;
      cover_mask = ~cv;
      cursor_opt = ~cur;
      shift_x = '0;
      shift_y = '0;
      // R2: armed keeps normal refresh
      sweep(0, 0, 0, mv, cv, cur, salt);
      chk("R2 still armed", busy, 1);
      frame_pulse();
      // R10: start request while busy is ignored
      @(negedge clk);
      start_req = 1;
      @(negedge clk);
      start_req = 0;
      sweep(1, sx, sy, mv, cv, cur, salt);
      chk("R7 no step without frame_start", dm_we, 0);
      frame_pulse();
      sweep(2, sx, sy, mv, cv, cur, salt + 1);
      frame_pulse();
      chk("R7 writeback phase", mon_from_dm, 1);
      sweep(3, sx, sy, mv, cv, cur, salt + 2);
      chk("R8 no done before end", done, 0);
      frame_pulse();
      chk("R8 done pulse", done, 1);
      chk("R8 busy low", busy, 0);
      @(negedge clk);
      chk("R8 done one cycle", done, 0);
      // R10: nothing restarted, back to normal refresh
      frame_pulse();
      chk("R10 stays idle", busy, 0);
      sweep(0, 0, 0, mv, cv, cur, salt + 3);
   endtask

   initial begin
      #1;
      chk("R1 reset busy", busy, 0);
      chk("R1 reset mon", mon_from_dm, 0);
      chk("R8 reset done", done, 0);
      repeat (3) @(negedge clk);
      rst_n = 1;
      sweep(0, 0, 0, '0, '0, 1'b0, 0);
      frame_pulse();
      chk("R2 frame alone does not start", busy, 0);
      run_move(3, 2, 8'b0000_0110, 8'b0001_0000, 1'b1, 1);
      run_move(-5, -3, 8'b1000_0001, 8'b0110_0000, 1'b0, 2);
      run_move(15, 7, 8'hFF, 8'h00, 1'b1, 3);
      run_move(-16, -8, 8'hFF, 8'hFF, 1'b0, 4);
      run_move(0, 0, 8'b0101_0101, 8'b1010_1010, 1'b1, 5);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      errors++;
      checks++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule